// File: doc/BRIEF.md
# Quad-Channel Register Front-End with Broadcast Write

This block is the host-facing register access logic of a four-channel serial controller. One shared chip select, one read strobe and one write strobe reach every channel. A 7-bit address has three fields. The top bit picks either the per-channel space or the global space. The next two bits pick a channel. The low four bits pick one of sixteen registers in a flat map, where every register can be reached directly with no banking and no unlock sequence. Each channel is modelled as a bank of sixteen plain 8-bit registers and four interrupt-source inputs that set pending flags.

The global space holds a configuration register and a global interrupt status register. Bit 0 of the configuration register turns on broadcast mode. In broadcast mode one write to any channel's register offset updates that offset in all four channels. Reads are never broadcast. A single active-high level interrupt output is the OR of the pending flags of all channels. A read of the global status register returns which channels have something pending and the highest-priority source of each channel. The same read clears one pending source in every channel, so one service pass acknowledges all four channels.

Top module: `quad_reg_frontend`

## Requirements
- R1: After a synchronous active-low reset, all channel registers, all pending flags, the broadcast bit, `rdata` and `irq_out` are zero.
- R2: With `addr[6]`=0, `addr[5:4]` selects the channel and `addr[3:0]` the register. A write with broadcast off stores `wdata` in that channel only. A read loads the zero-extended register value into `rdata` on the next clock edge.
- R3: With `cs` low, write and read strobes have no effect: no register changes and `rdata` holds its last value.
- R4: Global offset 0 (`addr[6]`=1, `addr[3:0]`=0, channel bits ignored) is the configuration register. Bit 0 is the broadcast enable. It reads back in `rdata[0]` and all other bits read as zero.
- R5: While broadcast is enabled, a channel-space write stores `wdata` at the addressed offset in all four channels.
- R6: While broadcast is enabled, a channel-space read returns the register of the addressed channel only.
- R7: A high bit `irq_src[4*c+s]` on a clock edge sets pending source s of channel c. `irq_out` is high, one cycle later and for as long as any source of any channel is pending.
- R8: Global offset 1 is the status register. `rdata[3:0]` has bit c set when channel c has a pending source. `rdata[5+2c:4+2c]` holds the lowest-numbered pending source of channel c, or 0 if none is pending. Source 0 is line status, 1 is receive data, 2 is transmit empty and 3 is modem status. `rdata[11:12-0]` above bit 11 does not exist and bits above the fields read zero.
- R9: A read of the status register returns the value from before the clear. In the same edge it clears exactly the lowest-numbered pending source in every channel that has one.
- R10: Writes to the status register or to global offsets 2 to 15 are ignored, and reads of global offsets 2 to 15 return zero.
- R11: If a source is set on the same edge that a status read would clear it, it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Shared chip select, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | {global, channel[1:0], offset[3:0]} |
| wdata | input | 8 | Write data |
| rdata | output | 12 | Registered read data |
| irq_src | input | 16 | Interrupt source set pulses, 4 per channel |
| irq_out | output | 1 | Combined interrupt, active high level |

## Verification
Directed sequences first write different values to the same offset in different channels, then switch broadcast on. This separates a write that reaches one channel from one that reaches all four. It also separates a read that follows the channel field from one that does not. Interrupt patterns set several sources in several channels at once and then issue repeated status reads. This shows whether exactly one source per channel is cleared, in priority order and across all channels together, and whether a set in the same cycle as a clear survives. A seeded random mix of writes, reads, configuration changes, chip-select-low cycles and sparse interrupt pulses follows. Every cycle is compared against a bench model of the registers, the broadcast bit and the pending flags.

// File: rtl/qrf_pkg.sv
// Package: constants shared by the quad register front-end.
// Assumes four interrupt sources per channel, numbered in priority order.
package qrf_pkg;
    localparam int NUM_SRC = 4;
    localparam int SRC_W   = 2;

    // Register offsets inside the global decode region
    localparam logic [3:0] GOFF_CFG  = 4'd0;
    localparam logic [3:0] GOFF_STAT = 4'd1;

    // Source numbering, lowest value is serviced first
    typedef enum logic [SRC_W-1:0] {
        SRC_LINE  = 2'd0,
        SRC_RX    = 2'd1,
        SRC_TX    = 2'd2,
        SRC_MODEM = 2'd3
    } src_code_e;
endpackage

// File: rtl/qrf_decode.sv
// Address decoder: splits the address into region, channel and offset, and
// produces per-channel write enables (all of them in broadcast mode), the
// configuration write strobe and the read-kind selects.
// Assumes NUM_CH is a power of two so the channel field is fully decoded.
module qrf_decode
    import qrf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int OFF_W  = 4,
    localparam int ADDR_W = 1 + CH_W + OFF_W
) (
    input  logic              cs,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bcast,
    output logic [NUM_CH-1:0] ch_we,
    output logic              cfg_we,
    output logic              rd_ch_hit,
    output logic              rd_cfg_hit,
    output logic              rd_stat_hit,
    output logic [CH_W-1:0]   sel_ch,
    output logic [OFF_W-1:0]  sel_off
);
    logic is_glob;
    logic acc_wr;
    logic acc_rd;

    assign is_glob = addr[ADDR_W-1];
    assign sel_ch  = addr[OFF_W +: CH_W];
    assign sel_off = addr[OFF_W-1:0];
    assign acc_wr  = cs & wr_en;
    assign acc_rd  = cs & rd_en;

    // Per-channel write enable: addressed channel, or every channel in broadcast
    for (genvar i = 0; i < NUM_CH; i++) begin : g_we
        assign ch_we[i] = acc_wr & ~is_glob & (bcast | (sel_ch == CH_W'(i)));
    end

    // Global-region strobes; status is read-only, other offsets are unmapped
    assign cfg_we      = acc_wr & is_glob & (sel_off == OFF_W'(GOFF_CFG));
    assign rd_ch_hit   = acc_rd & ~is_glob;
    assign rd_cfg_hit  = acc_rd & is_glob & (sel_off == OFF_W'(GOFF_CFG));
    assign rd_stat_hit = acc_rd & is_glob & (sel_off == OFF_W'(GOFF_STAT));
endmodule

// File: rtl/qrf_chan.sv
// One channel: a flat bank of registers and a set of sticky pending flags.
// An acknowledge clears the lowest-numbered pending flag. A set in the same
// cycle wins. Assumes rd_data is sampled by a register in the parent.
module qrf_chan
    import qrf_pkg::*;
#(
    parameter int OFF_W = 4,
    parameter int REG_W = 8,
    localparam int DEPTH = 1 << OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [OFF_W-1:0]   off,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic               ack,
    output logic               pend_any,
    output logic [SRC_W-1:0]   top_code
);
    logic [REG_W-1:0]   bank [DEPTH];
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] pend_clr;

    // Register storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
        end else if (we) begin
            bank[off] <= wdata;
        end
    end

    assign rd_data = bank[off];

    // Isolate the lowest pending bit when acknowledged
    assign pend_clr = ack ? (pend & (~pend + NUM_SRC'(1))) : '0;

    // Pending flags: clear one on acknowledge, then merge new sets
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~pend_clr) | src_set;
    end

    // Priority encoder: lowest-numbered pending source
    always_comb begin
        top_code = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (pend[s]) top_code = SRC_W'(s);
        end
    end

    assign pend_any = |pend;

    // An acknowledge with no new sets removes exactly one source
    p_one_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && src_set == '0 && pend != '0) |=>
            ($countones(pend) + 1 == $countones($past(pend))));

    // Without acknowledge no pending source is ever dropped
    p_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> ((pend & $past(pend)) == $past(pend)));

    // Every source set is pending on the next cycle, even under acknowledge
    p_set_sticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((pend & $past(src_set)) == $past(src_set)));
endmodule

// File: rtl/qrf_irq_merge.sv
// Interrupt combiner: ORs the channel requests into one level output and
// packs the global status word as {codes of all channels, pending vector}.
// Assumes each channel reports code 0 when nothing is pending.
module qrf_irq_merge
    import qrf_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int STAT_W = NUM_CH * (1 + SRC_W)
) (
    input  logic [NUM_CH-1:0]       ch_any,
    input  logic [NUM_CH*SRC_W-1:0] ch_code,
    output logic                    irq_out,
    output logic [STAT_W-1:0]       stat_word
);
    // Level interrupt and packed status
    assign irq_out   = |ch_any;
    assign stat_word = {ch_code, ch_any};
endmodule

// File: rtl/quad_reg_frontend.sv
// Top: host register front-end for four serial channels. It decodes the
// address, holds the broadcast configuration bit, instantiates the channel
// banks, merges the interrupts and registers the read data.
// Assumes reads complete in one cycle and rdata holds between reads.
module quad_reg_frontend
    import qrf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int OFF_W  = 4,
    parameter int REG_W  = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = 1 + CH_W + OFF_W,
    localparam int STAT_W = NUM_CH * (1 + SRC_W),
    localparam int DW     = (REG_W > STAT_W) ? REG_W : STAT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    output logic [DW-1:0]             rdata,
    input  logic [NUM_CH*NUM_SRC-1:0] irq_src,
    output logic                      irq_out
);
    logic                    bcast;
    logic [NUM_CH-1:0]       ch_we;
    logic                    cfg_we;
    logic                    rd_ch_hit;
    logic                    rd_cfg_hit;
    logic                    rd_stat_hit;
    logic [CH_W-1:0]         sel_ch;
    logic [OFF_W-1:0]        sel_off;
    logic [REG_W-1:0]        ch_rd [NUM_CH];
    logic [NUM_CH-1:0]       ch_any;
    logic [NUM_CH*SRC_W-1:0] ch_code;
    logic [STAT_W-1:0]       stat_word;
    logic [DW-1:0]           rdata_d;

    qrf_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .OFF_W(OFF_W)) u_decode (
        .cs         (cs),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .bcast      (bcast),
        .ch_we      (ch_we),
        .cfg_we     (cfg_we),
        .rd_ch_hit  (rd_ch_hit),
        .rd_cfg_hit (rd_cfg_hit),
        .rd_stat_hit(rd_stat_hit),
        .sel_ch     (sel_ch),
        .sel_off    (sel_off)
    );

    // Broadcast enable held in bit 0 of the configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)      bcast <= 1'b0;
        else if (cfg_we) bcast <= wdata[0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qrf_chan #(.OFF_W(OFF_W), .REG_W(REG_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (ch_we[c]),
            .off     (sel_off),
            .wdata   (wdata),
            .rd_data (ch_rd[c]),
            .src_set (irq_src[c*NUM_SRC +: NUM_SRC]),
            .ack     (rd_stat_hit),
            .pend_any(ch_any[c]),
            .top_code(ch_code[c*SRC_W +: SRC_W])
        );
    end

    qrf_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
        .ch_any   (ch_any),
        .ch_code  (ch_code),
        .irq_out  (irq_out),
        .stat_word(stat_word)
    );

    // Read mux: addressed channel, configuration or status; zero otherwise
    always_comb begin
        rdata_d = '0;
        if (rd_ch_hit)        rdata_d[REG_W-1:0]  = ch_rd[sel_ch];
        else if (rd_cfg_hit)  rdata_d[0]          = bcast;
        else if (rd_stat_hit) rdata_d[STAT_W-1:0] = stat_word;
    end

    // Read data register, updated only on a selected read
    always_ff @(posedge clk) begin
        if (!rst_n)            rdata <= '0;
        else if (cs && rd_en)  rdata <= rdata_d;
    end

    // Without a selected read the read data does not move
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd_en) |=> $stable(rdata));

    // A configuration write lands in the broadcast bit
    p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_en && addr[ADDR_W-1] && addr[OFF_W-1:0] == OFF_W'(GOFF_CFG))
            |=> (bcast == $past(wdata[0])));

    // Any source pulse raises the interrupt on the next cycle
    p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src != '0) |=> irq_out);

    // Outside broadcast at most one channel is written per cycle
    p_single_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bcast |-> $onehot0(ch_we));
endmodule

// File: tb/quad_reg_frontend_tb.sv
// Bench: directed corner cases plus seeded random traffic, compared each
// cycle against a model of registers, broadcast bit and pending flags.
module quad_reg_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs, wr_en, rd_en;
    logic [6:0]  addr;
    logic [7:0]  wdata;
    logic [11:0] rdata;
    logic [15:0] irq_src;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  m_reg [4][16];
    logic        m_bc;
    logic [3:0]  m_pend [4];
    logic [11:0] m_rd;

    always #5 clk = ~clk;

    quad_reg_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_src(irq_src),
        .irq_out(irq_out)
    );

    function automatic logic [11:0] stat_fn();
        logic [11:0] v = '0;
        for (int c = 0; c < 4; c++) begin
            v[c] = |m_pend[c];
            for (int s = 3; s >= 0; s--)
                if (m_pend[c][s]) v[4+2*c +: 2] = 2'(s);
        end
        return v;
    endfunction

    function automatic logic [11:0] exp_read(logic [6:0] a);
        if (!a[6]) return {4'b0, m_reg[a[5:4]][a[3:0]]};
        if (a[3:0] == 4'd0) return {11'b0, m_bc};
        if (a[3:0] == 4'd1) return stat_fn();
        return '0;
    endfunction

    task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, update model, sample at next negedge
    task automatic op(bit c, bit w, bit r, logic [6:0] a, logic [7:0] d,
                      logic [15:0] s, string tag);
        cs = c; wr_en = w; rd_en = r; addr = a; wdata = d; irq_src = s;
        if (c && r) m_rd = exp_read(a);
        if (c && w) begin
            if (!a[6]) begin
                for (int ch = 0; ch < 4; ch++)
                    if (m_bc || a[5:4] == 2'(ch)) m_reg[ch][a[3:0]] = d;
            end else if (a[3:0] == 4'd0) begin
                m_bc = d[0];
            end
        end
        if (c && r && a[6] && a[3:0] == 4'd1)
            for (int ch = 0; ch < 4; ch++)
                m_pend[ch] = m_pend[ch] & ~(m_pend[ch] & (~m_pend[ch] + 4'd1));
        for (int ch = 0; ch < 4; ch++) m_pend[ch] = m_pend[ch] | s[ch*4 +: 4];
        @(negedge clk);
        check(tag, rdata, m_rd);
        check("R7 irq_out", {11'b0, irq_out},
              {11'b0, (|m_pend[0]) | (|m_pend[1]) | (|m_pend[2]) | (|m_pend[3])});
    endtask

    function automatic logic [6:0] ca(int ch, int off);
        return {1'b0, 2'(ch), 4'(off)};
    endfunction

    localparam logic [6:0] A_CFG  = 7'h40;
    localparam logic [6:0] A_STAT = 7'h41;

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; cs = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; irq_src = '0;
        m_bc = 0; m_rd = '0;
        for (int c = 0; c < 4; c++) begin
            m_pend[c] = '0;
            for (int o = 0; o < 16; o++) m_reg[c][o] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 rdata", rdata, 12'h0);
        check("R1 irq", {11'b0, irq_out}, 12'h0);
        rst_n = 1'b1;
        op(1, 0, 1, ca(2, 5), 8'h00, 16'h0, "R1 reg");
        op(1, 0, 1, A_CFG, 8'h00, 16'h0, "R1 cfg");
        op(1, 0, 1, A_STAT, 8'h00, 16'h0, "R1 stat");

        // R2 single-channel write and read
        op(1, 1, 0, ca(1, 3), 8'hA5, 16'h0, "R2 wr");
        op(1, 0, 1, ca(1, 3), 8'h00, 16'h0, "R2 rd");
        op(1, 0, 1, ca(0, 3), 8'h00, 16'h0, "R2 other ch");
        op(1, 1, 0, ca(3, 15), 8'hFF, 16'h0, "R2 wr top");
        op(1, 0, 1, ca(3, 15), 8'h00, 16'h0, "R2 rd top");

        // R3 chip select low
        op(0, 1, 0, ca(1, 3), 8'h11, 16'h0, "R3 wr");
        op(1, 0, 1, ca(1, 3), 8'h00, 16'h0, "R3 rd");
        op(0, 0, 1, ca(0, 0), 8'h00, 16'h0, "R3 hold");
        op(0, 1, 0, A_CFG, 8'h01, 16'h0, "R3 cfg");
        op(1, 0, 1, A_CFG, 8'h00, 16'h0, "R3 cfg rd");

        // R6 setup: distinct values before broadcast
        op(1, 1, 0, ca(0, 2), 8'h01, 16'h0, "R6 wr0");
        op(1, 1, 0, ca(1, 2), 8'h02, 16'h0, "R6 wr1");

        // R4 configuration register
        op(1, 1, 0, A_CFG, 8'hFF, 16'h0, "R4 wr");
        op(1, 0, 1, A_CFG, 8'h00, 16'h0, "R4 rd");
        op(1, 0, 1, ca(1, 2), 8'h00, 16'h0, "R6 rd ch1");
        op(1, 0, 1, ca(0, 2), 8'h00, 16'h0, "R6 rd ch0");

        // R5 broadcast write
        op(1, 1, 0, ca(2, 7), 8'h3C, 16'h0, "R5 wr");
        for (int c = 0; c < 4; c++) op(1, 0, 1, ca(c, 7), 8'h00, 16'h0, "R5 rd");
        op(1, 1, 0, A_CFG, 8'h00, 16'h0, "R4 off");
        op(1, 0, 1, A_CFG, 8'h00, 16'h0, "R4 rd off");

        // R7/R8/R9 interrupts: ch0 sources 1 and 3, ch2 source 0, ch3 all
        op(1, 0, 0, ca(0, 0), 8'h00, 16'hF10A, "R7 set");
        op(1, 0, 1, A_STAT, 8'h00, 16'h0, "R8 stat");
        for (int k = 0; k < 4; k++) op(1, 0, 1, A_STAT, 8'h00, 16'h0, "R9 stat");

        // R11 set during clear
        op(1, 0, 0, ca(0, 0), 8'h00, 16'h0010, "R11 set");
        op(1, 0, 1, A_STAT, 8'h00, 16'h0010, "R11 collide");
        op(1, 0, 1, A_STAT, 8'h00, 16'h0, "R11 after");
        op(1, 0, 1, A_STAT, 8'h00, 16'h0, "R11 drained");

        // R10 read-only and unmapped global offsets
        op(1, 0, 0, ca(0, 0), 8'h00, 16'h0004, "R10 set");
        op(1, 1, 0, A_STAT, 8'hFF, 16'h0, "R10 wr stat");
        op(1, 1, 0, 7'h45, 8'hFF, 16'h0, "R10 wr unmapped");
        op(1, 0, 1, 7'h45, 8'h00, 16'h0, "R10 rd unmapped");
        op(1, 0, 1, A_CFG, 8'h00, 16'h0, "R10 cfg");
        op(1, 0, 1, A_STAT, 8'h00, 16'h0, "R10 stat");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int k = int'($urandom % 8);
            bit c = ($urandom % 10) != 0;
            logic [15:0] s = (($urandom % 4) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
            logic [7:0] d = 8'($urandom);
            int ch = int'($urandom % 4);
            int off = int'($urandom % 16);
            string tag;
            if (!c)               tag = "R3 rand";
            else if (k < 3)       tag = m_bc ? "R5 rand" : "R2 rand";
            else if (k < 6)       tag = m_bc ? "R6 rand" : "R2 rand";
            else if (k == 6)      tag = "R9 rand";
            else                  tag = "R4 rand";
            if (k < 3)       op(c, 1, 0, ca(ch, off), d, s, tag);
            else if (k < 6)  op(c, 0, 1, ca(ch, off), d, s, tag);
            else if (k == 6) op(c, 0, 1, {1'b1, 2'(ch), 4'(off % 3)}, d, s, tag);
            else             op(c, 1, 1, A_CFG, d, s, tag);
        end

        for (int k = 0; k < 6; k++) op(1, 0, 1, A_STAT, 8'h00, 16'h0, "R9 drain");
        op(0, 0, 0, ca(0, 0), 8'h00, 16'h0, "R7 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule